// File: doc/BRIEF.md
# Jitter-Smoothing Elastic Buffer

This block sits between a recovered line clock that carries jitter and a clean read clock of the same average rate. Each line bit is a dual-rail pair (positive mark, negative mark). Pairs are written into a 128-entry store on the jittery clock and read out on the clean clock, so phase wander on the input does not appear at the output. The clean clock comes from outside the block.

An active-low recenter input clears both sides while it is low. On its release, the read side waits for the synchronised release, then places its read pointer half the store behind the synchronised write pointer. A limit flag rises when the fill level drifts more than 60 entries from centre. If the store is about to run dry or wrap, the read side recenters by itself and raises the flag for at least one read cycle. A bypass input routes the write clock and write data straight to the outputs, with their jitter unchanged.

The read side is a four-state machine. IDLE is held while the synchronised recenter is low. IDLE goes to ALIGN on release. ALIGN loads the read pointer and always goes to RUN. RUN reads one pair per cycle. RUN goes to SLIP when the fill is within two entries of empty or full, and otherwise stays in RUN. SLIP reloads the read pointer, holds the flag high and always returns to RUN. The write pointer crosses to the read clock in Gray code through two flops.

Top module: `jitter_elastic_buffer`

## Requirements
- R1: When not bypassed, the output pair sequence equals the written pair sequence, in order, with no pairs dropped or repeated between recenter events.
- R2: After a recenter, the read side lags the write side by half the depth (64 entries) plus synchroniser and register latency: 60 to 78 write cycles from the write of a pair to the read clock sample that shows it.
- R3: While recenter_n is low, out_pos, out_neg and limit are 0 (bypass off). Recentering takes effect on the release of recenter_n and removes any fill offset built up before it.
- R4: limit is 1 when the read-side fill differs from 64 by more than 60. It stays 0 while input wander stays well inside that window.
- R5: When the fill reaches 0, 1, 126 or 127, the read side recenters to half-full without a command. limit is 1 for at least one read cycle, and the data stream then resumes in order.
- R6: With attn_off = 1, out_clk follows wr_clk, and out_pos/out_neg follow wr_pos/wr_neg, combinationally.
- R7: With attn_off = 0, out_clk follows rd_clk, and out_pos/out_neg change only on the rising edge of rd_clk.
- R8: The write pointer's Gray code changes in at most one bit per write clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Jittery recovered line clock (write side) |
| wr_pos | input | 1 | Positive-mark rail of the incoming pair |
| wr_neg | input | 1 | Negative-mark rail of the incoming pair |
| rd_clk | input | 1 | Clean read clock |
| recenter_n | input | 1 | Active-low clear; release recenters the buffer |
| attn_off | input | 1 | 1 = bypass the store, 0 = smooth through the store |
| out_clk | output | 1 | Output clock (rd_clk, or wr_clk in bypass) |
| out_pos | output | 1 | Positive-mark rail out |
| out_neg | output | 1 | Negative-mark rail out |
| limit | output | 1 | Fill deviation beyond the limit, or automatic recenter |

## Verification
Random two-bit pairs are written while the write period is jittered at random around the read period. A window of read samples is then located in the write history, which shows ordering and the centred lag. A slow up-and-down wander keeps the flag low and separates real limit events from ordinary jitter. A steady fast or slow write clock drives the store to wrap or to run dry, which shows the flag, the automatic recenter and the restored lag. A fill offset built up on purpose, followed by a recenter pulse, shows that the command removes the offset. Sampling the outputs against both clocks, with bypass on and off, shows which path drives them.

// File: rtl/eb_pkg.sv
package eb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_RUN,
        ST_SLIP
    } rd_state_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } pair_t;

endpackage

// File: rtl/eb_sync2.sv
module eb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/eb_wr_ptr.sv
module eb_wr_ptr #(
    parameter int AW = 7
) (
    input  logic          wr_clk,
    input  logic          arst_n,
    output logic          wr_en,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] wgray
);
    logic          rel;
    logic [AW-1:0] wnext;

    eb_sync2 #(.W(1)) u_rel (
        .clk    (wr_clk),
        .arst_n (arst_n),
        .d      (1'b1),
        .q      (rel)
    );

    assign wr_en = rel;
    assign wnext = wptr + AW'(1);

    always_ff @(posedge wr_clk or negedge arst_n) begin
        if (!arst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (rel) begin
            wptr  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    // R8: one bit per step in the crossing code
    p_gray_step_r8: assert property (@(posedge wr_clk) disable iff (!arst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/eb_rd_fsm.sv
module eb_rd_fsm
    import eb_pkg::*;
#(
    parameter int AW      = 7,
    parameter int DEPTH   = 128,
    parameter int DEV_LIM = 60,
    parameter int MARGIN  = 2
) (
    input  logic          rd_clk,
    input  logic          arst_n,
    input  logic          rel,
    input  logic [AW-1:0] wsync,
    input  pair_t         rdata,
    output logic [AW-1:0] raddr,
    output pair_t         out_q,
    output logic          limit_q
);
    localparam int HALF = DEPTH / 2;
    localparam logic [AW-1:0] HALF_L = AW'(HALF);
    localparam logic [AW-1:0] HI_L   = AW'(HALF + DEV_LIM);
    localparam logic [AW-1:0] LO_L   = AW'(HALF - DEV_LIM);
    localparam logic [AW-1:0] FULL_L = AW'(DEPTH - 1 - MARGIN);
    localparam logic [AW-1:0] DRY_L  = AW'(MARGIN);

    rd_state_t     st, st_nx;
    logic [AW-1:0] rptr;
    logic [AW-1:0] fill;
    logic          slip_now;
    logic          dev_now;

    assign raddr    = rptr;
    assign fill     = wsync - rptr;
    assign slip_now = (fill < DRY_L) || (fill > FULL_L);
    assign dev_now  = (fill > HI_L) || (fill < LO_L);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (rel) st_nx = ST_ALIGN;
            ST_ALIGN: st_nx = ST_RUN;
            ST_RUN:   if (slip_now) st_nx = ST_SLIP;
            ST_SLIP:  st_nx = ST_RUN;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge rd_clk or negedge arst_n) begin
        if (!arst_n) st <= ST_IDLE;
        else         st <= st_nx;
    end

    always_ff @(posedge rd_clk or negedge arst_n) begin
        if (!arst_n) begin
            rptr    <= '0;
            out_q   <= '0;
            limit_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    out_q   <= '0;
                    limit_q <= 1'b0;
                end
                ST_ALIGN: begin
                    rptr    <= wsync - HALF_L;
                    out_q   <= '0;
                    limit_q <= 1'b0;
                end
                ST_RUN: begin
                    if (!slip_now) rptr <= rptr + AW'(1);
                    out_q   <= rdata;
                    limit_q <= dev_now | slip_now;
                end
                ST_SLIP: begin
                    rptr    <= wsync - HALF_L;
                    limit_q <= 1'b1;
                end
                default: begin
                    out_q   <= '0;
                    limit_q <= 1'b0;
                end
            endcase
        end
    end

    // R2: alignment places the reader half the store behind
    p_align_half_r2: assert property (@(posedge rd_clk) disable iff (!arst_n)
        (st == ST_ALIGN) |=> (AW'($past(wsync) - rptr) == HALF_L));

    // R5: an automatic recenter is flagged for the cycle that follows
    p_slip_flag_r5: assert property (@(posedge rd_clk) disable iff (!arst_n)
        (st == ST_SLIP) |=> limit_q);

    // R5: a recenter is a single cycle, then reading resumes
    p_slip_return_r5: assert property (@(posedge rd_clk) disable iff (!arst_n)
        (st == ST_SLIP) |=> (st == ST_RUN));

    // R3: nothing is shown before the reader is aligned
    p_idle_quiet_r3: assert property (@(posedge rd_clk) disable iff (!arst_n)
        (st == ST_IDLE) |=> (!limit_q && out_q.pos == 1'b0 && out_q.neg == 1'b0));
endmodule

// File: rtl/jitter_elastic_buffer.sv
module jitter_elastic_buffer
    import eb_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int DEV_LIM = 60
) (
    input  logic wr_clk,
    input  logic wr_pos,
    input  logic wr_neg,
    input  logic rd_clk,
    input  logic recenter_n,
    input  logic attn_off,
    output logic out_clk,
    output logic out_pos,
    output logic out_neg,
    output logic limit
);
    localparam int AW = $clog2(DEPTH);

    pair_t         store [DEPTH];
    logic          wr_en;
    logic [AW-1:0] wptr;
    logic [AW-1:0] wgray;
    logic [AW-1:0] wgray_rd;
    logic [AW-1:0] wsync;
    logic          rd_rel;
    logic [AW-1:0] raddr;
    pair_t         rdata;
    pair_t         rsym;

    eb_wr_ptr #(.AW(AW)) u_wr (
        .wr_clk (wr_clk),
        .arst_n (recenter_n),
        .wr_en  (wr_en),
        .wptr   (wptr),
        .wgray  (wgray)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_en) store[wptr] <= '{pos: wr_pos, neg: wr_neg};
    end

    eb_sync2 #(.W(AW)) u_ptr_sync (
        .clk    (rd_clk),
        .arst_n (recenter_n),
        .d      (wgray),
        .q      (wgray_rd)
    );

    genvar gi;
    generate
        for (gi = 0; gi < AW; gi++) begin : g_g2b
            assign wsync[gi] = ^wgray_rd[AW-1:gi];
        end
    endgenerate

    eb_sync2 #(.W(1)) u_rel_sync (
        .clk    (rd_clk),
        .arst_n (recenter_n),
        .d      (1'b1),
        .q      (rd_rel)
    );

    assign rdata = store[raddr];

    eb_rd_fsm #(
        .AW      (AW),
        .DEPTH   (DEPTH),
        .DEV_LIM (DEV_LIM),
        .MARGIN  (2)
    ) u_rd (
        .rd_clk  (rd_clk),
        .arst_n  (recenter_n),
        .rel     (rd_rel),
        .wsync   (wsync),
        .rdata   (rdata),
        .raddr   (raddr),
        .out_q   (rsym),
        .limit_q (limit)
    );

    assign out_clk = attn_off ? wr_clk : rd_clk;
    assign out_pos = attn_off ? wr_pos : rsym.pos;
    assign out_neg = attn_off ? wr_neg : rsym.neg;
endmodule

// File: tb/sim_jitter_elastic_buffer.sv
`timescale 1ns/1ps
module sim_jitter_elastic_buffer;
    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wp = 1'b0, wn = 1'b0;
    logic recenter_n = 1'b0, attn_off = 1'b0;
    logic out_clk, out_pos, out_neg, limit;

    int   n_chk = 0, n_bad = 0;
    bit   jit_on = 1'b0;
    real  wbias = 0.0;
    logic [1:0] hist [65536];
    int   wcnt = 0;

    jitter_elastic_buffer u0 (
        .wr_clk(wr_clk), .wr_pos(wp), .wr_neg(wn), .rd_clk(rd_clk),
        .recenter_n(recenter_n), .attn_off(attn_off),
        .out_clk(out_clk), .out_pos(out_pos), .out_neg(out_neg), .limit(limit)
    );

    always #2 rd_clk = ~rd_clk;   // 250 MHz read clock

    function automatic real wr_period(bit jit, real bias, int unsigned r);
        real p;
        p = 4.0 + bias;
        if (jit) p = p + (real'(int'(r % 9) - 4)) * 0.1;
        return p;
    endfunction

    initial begin
        forever begin
            real p;
            p = wr_period(jit_on, wbias, $urandom);
            #(p / 2.0) wr_clk = 1'b1;
            #(p / 2.0) wr_clk = 1'b0;
        end
    end

    always @(posedge wr_clk) begin
        if (wcnt < 65536) hist[wcnt] = {wp, wn};
        wcnt++;
    end

    always @(posedge wr_clk) begin
        #0.5;
        {wp, wn} = 2'($urandom);
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // locate 12 consecutive read samples in recent write history
    task automatic measure(output bit found, output int lag);
        logic [1:0] r [12];
        int wc;
        found = 1'b0;
        lag   = -1;
        for (int k = 0; k < 12; k++) begin
            @(posedge rd_clk); #1;
            r[k] = {out_pos, out_neg};
        end
        wc = wcnt;
        for (int j = wc - 12; j >= wc - 400 && j >= 0; j--) begin
            bit m;
            m = 1'b1;
            for (int k = 0; k < 12; k++) if (hist[j + k] !== r[k]) m = 1'b0;
            if (m && !found) begin
                found = 1'b1;
                lag   = wc - (j + 11);
            end
        end
    endtask

    task automatic watch(int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge rd_clk); #1;
            if (limit) hi++;
        end
    endtask

    task automatic drive_slip(real bias, string req);
        int waited, hi_len;
        bit f; int lg;
        wbias = bias;
        waited = 0;
        while (!limit && waited < 6000) begin
            @(posedge rd_clk); #1; waited++;
        end
        chk(limit == 1'b1, {req, " limit raised"}, int'(limit), 1);
        hi_len = 0;
        while (limit && hi_len < 60) begin
            @(posedge rd_clk); #1; hi_len++;
        end
        chk(hi_len >= 1 && hi_len < 60, {req, " flag width"}, hi_len, 1);
        wbias = 0.0;
        repeat (20) @(posedge rd_clk);
        measure(f, lg);
        chk(f, {req, " stream resumes R1"}, int'(f), 1);
        chk(lg >= 60 && lg <= 82, {req, " recentred lag"}, lg, 69);
    endtask

    initial begin
        #600us;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        bit f; int lg, hi;
        void'($urandom(32'd2024));

        // R3: held in clear
        repeat (10) @(posedge rd_clk);
        #1;
        chk(out_pos == 1'b0, "R3 out_pos in clear", int'(out_pos), 0);
        chk(out_neg == 1'b0, "R3 out_neg in clear", int'(out_neg), 0);
        chk(limit == 1'b0, "R3 limit in clear", int'(limit), 0);

        recenter_n = 1'b1;
        repeat (150) @(posedge rd_clk);
        measure(f, lg);
        chk(f, "R1 ordered stream", int'(f), 1);
        chk(lg >= 60 && lg <= 78, "R2 centred lag", lg, 69);

        // random jitter
        jit_on = 1'b1;
        watch(1500, hi);
        chk(hi == 0, "R4 limit low under jitter", hi, 0);
        measure(f, lg);
        chk(f, "R1 stream under jitter", int'(f), 1);
        chk(lg >= 58 && lg <= 80, "R2 lag under jitter", lg, 69);

        // slow wander of about +-15 entries
        wbias = -0.2; watch(300, hi);
        chk(hi == 0, "R4 limit low wander up", hi, 0);
        wbias = 0.2;  watch(600, hi);
        chk(hi == 0, "R4 limit low wander down", hi, 0);
        wbias = -0.2; watch(300, hi);
        chk(hi == 0, "R4 limit low wander back", hi, 0);
        wbias = 0.0;
        measure(f, lg);
        chk(f, "R1 stream after wander", int'(f), 1);

        // R5 wrap and run-dry
        drive_slip(-0.2, "R5 overflow");
        drive_slip(0.2, "R5 underflow");

        // R3 manual recenter removes offset
        wbias = -0.2;
        repeat (500) @(posedge rd_clk);
        wbias = 0.0;
        measure(f, lg);
        chk(f && lg >= 82, "R3 offset built before recenter", lg, 94);
        recenter_n = 1'b0;
        repeat (4) @(posedge rd_clk);
        #1;
        chk(out_pos == 1'b0 && out_neg == 1'b0 && limit == 1'b0,
            "R3 outputs cleared", int'({out_pos, out_neg, limit}), 0);
        repeat (6) @(posedge rd_clk);
        recenter_n = 1'b1;
        repeat (150) @(posedge rd_clk);
        measure(f, lg);
        chk(f, "R1 stream after recenter", int'(f), 1);
        chk(lg >= 58 && lg <= 80, "R3 lag after recenter", lg, 69);

        // R6 bypass
        attn_off = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(posedge wr_clk); #1.1;
            chk(out_clk == wr_clk, "R6 clock follows write clock", int'(out_clk), int'(wr_clk));
            chk({out_pos, out_neg} == {wp, wn}, "R6 data follows input",
                int'({out_pos, out_neg}), int'({wp, wn}));
            @(negedge wr_clk); #0.3;
            chk(out_clk == wr_clk, "R6 clock low phase", int'(out_clk), int'(wr_clk));
        end

        // R7 normal path
        attn_off = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [1:0] a;
            @(posedge rd_clk); #1;
            a = {out_pos, out_neg};
            chk(out_clk == 1'b1, "R7 clock follows read clock", int'(out_clk), 1);
            @(negedge rd_clk); #1;
            chk(out_clk == 1'b0, "R7 clock low phase", int'(out_clk), 0);
            chk({out_pos, out_neg} == a, "R7 data stable between rising edges",
                int'({out_pos, out_neg}), int'(a));
        end

        summary();
    end
endmodule